// File: doc/BRIEF.md
# Iterative Feistel Round Engine for 64-bit Block Encryption

This block runs the Data Encryption Standard on one 64-bit block at a time. It has a single round of hardware and uses it again on each clock. A block is captured on one clock edge. The engine then applies sixteen rounds, one per edge, and returns a 64-bit result together with a one-cycle completion pulse. The result register keeps its value until the next block completes.

The round keys come from a key generator outside the block, one 48-bit key per round. The engine tells the generator which key it needs by presenting a 4-bit key index. In encryption the index counts up from the first key to the last. In decryption it counts down, so the same datapath inverts the cipher.

All bit reorderings are fixed wiring: the entry scramble, the half-width expansion, the post-substitution reorder and the exit scramble. The logic that remains is the eight substitution tables, the XOR stages and a small round sequencer.

Top module: `des_iter_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy` is 0, `done` is 0 and `blk_out` is all zeros.
- R2: When the engine is idle and `start_n` is low at a rising edge, the engine captures `blk_in` and `decrypt` on that edge and raises `busy`. While the engine is idle, `start_n` high leaves `busy` low and `blk_out` unchanged.
- R3: After the capturing edge, the engine applies exactly sixteen rounds, one per rising edge. `busy` falls on the sixteenth of those edges and `done` is high for that one cycle only. This gives a cadence of 17 edges per block.
- R4: `key_idx` runs 0,1,…,15 in encryption and 15,14,…,0 in decryption. The first value appears right after the capturing edge, and the index steps by one per round. The `rkey` present at an edge is the key applied in the round that edge completes.
- R5: Each round replaces (L,R) with (R, L XOR f(R,K)). f expands R from 32 to 48 bits, with each 6-bit group taking 4 bits plus one neighbour bit on each side, wrapping around. f then XORs the key and feeds the groups, most significant first, into substitution tables 1 to 8. Each table uses the outer two bits of its group as the row (0–3) and the inner four bits as the column (0–15). f finally reorders the concatenated 32-bit table output.
- R6: At the end the halves are swapped and the exit scramble is applied. With round keys derived from key 133457799BBCDFF1, encrypting 0123456789ABCDEF gives 85E813540F0AB405.
- R7: With `decrypt` high and the same keys supplied by index, the engine inverts encryption. 85E813540F0AB405 returns to 0123456789ABCDEF, and any block encrypted under any set of sixteen keys returns to its original value.
- R8: `start_n` low while `busy` is high does nothing: neither the block being processed, nor its mode, nor its timing changes.
- R9: `blk_out` changes only on the edge that raises `done`, and it holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Load request, active low, taken only when idle |
| decrypt | input | 1 | 1 selects decryption for the block being loaded |
| blk_in | input | 64 | Block to process, DES bit 1 at bit 63 |
| rkey | input | 48 | Round key for the round completing at the next edge |
| key_idx | output | 4 | Index of the round key the engine needs now |
| busy | output | 1 | Rounds in progress |
| blk_out | output | 64 | Last completed result |
| done | output | 1 | One-cycle pulse when `blk_out` is updated |

## Verification
The bench builds the engine with its default sixteen rounds. At that size every key index and every round edge can be seen on every block, so the key order and the 17-edge cadence are checked on each run. It checks the published key-answer pair against the fixed schedule in both directions. It then sweeps dozens of random sixteen-key sets over random blocks and requires decryption to undo encryption; this property of the Feistel structure needs no reference model. It also places load requests in the middle of blocks and starts blocks back to back, to exercise the rule that a busy engine ignores a new load.

// File: rtl/des_pkg.sv
package des_pkg;

    localparam int unsigned BLK_W  = 64;
    localparam int unsigned HALF_W = BLK_W / 2;
    localparam int unsigned RKEY_W = 48;
    localparam int unsigned N_SBOX = 8;
    localparam int unsigned GRP_W  = RKEY_W / N_SBOX;
    localparam int unsigned NIB_W  = HALF_W / N_SBOX;
    localparam int unsigned TAB_N  = 1 << GRP_W;

    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [RKEY_W-1:0] rkey_t;
    typedef logic [GRP_W-1:0]  grp_t;
    typedef logic [NIB_W-1:0]  nib_t;

    typedef struct packed {
        half_t lh;
        half_t rh;
    } halves_t;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Post-substitution reorder: entry i names the source bit (1-based, MSB first).
    localparam int unsigned PMAP [HALF_W] = '{
        16,  7, 20, 21, 29, 12, 28, 17,  1, 15, 23, 26,  5, 18, 31, 10,
         2,  8, 24, 14, 32, 27,  3,  9, 19, 13, 30,  6, 22, 11,  4, 25
    };

    // Substitution tables, stored row-major (row * 16 + column).
    localparam logic [3:0] SUB1 [TAB_N] = '{
        14,  4, 13,  1,  2, 15, 11,  8,  3, 10,  6, 12,  5,  9,  0,  7,
         0, 15,  7,  4, 14,  2, 13,  1, 10,  6, 12, 11,  9,  5,  3,  8,
         4,  1, 14,  8, 13,  6,  2, 11, 15, 12,  9,  7,  3, 10,  5,  0,
        15, 12,  8,  2,  4,  9,  1,  7,  5, 11,  3, 14, 10,  0,  6, 13
    };
    localparam logic [3:0] SUB2 [TAB_N] = '{
        15,  1,  8, 14,  6, 11,  3,  4,  9,  7,  2, 13, 12,  0,  5, 10,
         3, 13,  4,  7, 15,  2,  8, 14, 12,  0,  1, 10,  6,  9, 11,  5,
         0, 14,  7, 11, 10,  4, 13,  1,  5,  8, 12,  6,  9,  3,  2, 15,
        13,  8, 10,  1,  3, 15,  4,  2, 11,  6,  7, 12,  0,  5, 14,  9
    };
    localparam logic [3:0] SUB3 [TAB_N] = '{
        10,  0,  9, 14,  6,  3, 15,  5,  1, 13, 12,  7, 11,  4,  2,  8,
        13,  7,  0,  9,  3,  4,  6, 10,  2,  8,  5, 14, 12, 11, 15,  1,
        13,  6,  4,  9,  8, 15,  3,  0, 11,  1,  2, 12,  5, 10, 14,  7,
         1, 10, 13,  0,  6,  9,  8,  7,  4, 15, 14,  3, 11,  5,  2, 12
    };
    localparam logic [3:0] SUB4 [TAB_N] = '{
         7, 13, 14,  3,  0,  6,  9, 10,  1,  2,  8,  5, 11, 12,  4, 15,
        13,  8, 11,  5,  6, 15,  0,  3,  4,  7,  2, 12,  1, 10, 14,  9,
        10,  6,  9,  0, 12, 11,  7, 13, 15,  1,  3, 14,  5,  2,  8,  4,
         3, 15,  0,  6, 10,  1, 13,  8,  9,  4,  5, 11, 12,  7,  2, 14
    };
    localparam logic [3:0] SUB5 [TAB_N] = '{
         2, 12,  4,  1,  7, 10, 11,  6,  8,  5,  3, 15, 13,  0, 14,  9,
        14, 11,  2, 12,  4,  7, 13,  1,  5,  0, 15, 10,  3,  9,  8,  6,
         4,  2,  1, 11, 10, 13,  7,  8, 15,  9, 12,  5,  6,  3,  0, 14,
        11,  8, 12,  7,  1, 14,  2, 13,  6, 15,  0,  9, 10,  4,  5,  3
    };
    localparam logic [3:0] SUB6 [TAB_N] = '{
        12,  1, 10, 15,  9,  2,  6,  8,  0, 13,  3,  4, 14,  7,  5, 11,
        10, 15,  4,  2,  7, 12,  9,  5,  6,  1, 13, 14,  0, 11,  3,  8,
         9, 14, 15,  5,  2,  8, 12,  3,  7,  0,  4, 10,  1, 13, 11,  6,
         4,  3,  2, 12,  9,  5, 15, 10, 11, 14,  1,  7,  6,  0,  8, 13
    };
    localparam logic [3:0] SUB7 [TAB_N] = '{
         4, 11,  2, 14, 15,  0,  8, 13,  3, 12,  9,  7,  5, 10,  6,  1,
        13,  0, 11,  7,  4,  9,  1, 10, 14,  3,  5, 12,  2, 15,  8,  6,
         1,  4, 11, 13, 12,  3,  7, 14, 10, 15,  6,  8,  0,  5,  9,  2,
         6, 11, 13,  8,  1,  4, 10,  7,  9,  5,  0, 15, 14,  2,  3, 12
    };
    localparam logic [3:0] SUB8 [TAB_N] = '{
        13,  2,  8,  4,  6, 15, 11,  1, 10,  9,  3, 14,  5,  0, 12,  7,
         1, 15, 13,  8, 10,  3,  7,  4, 12,  5,  6, 11,  0, 14,  9,  2,
         7, 11,  4,  1,  9, 12, 14,  2,  0,  6, 10, 13, 15,  3,  5,  8,
         2,  1, 14,  7,  4, 10,  8, 13, 15, 12,  9,  0,  3,  5,  6, 11
    };

    // Source bit (1-based, MSB first) of entry-scramble output position i (0-based).
    function automatic int scr_src(input int i);
        int row;
        int col;
        row = i / 8;
        col = i % 8;
        return ((row < 4) ? (2 * row + 2) : (2 * row - 7)) + 8 * (7 - col);
    endfunction

    function automatic blk_t entry_scramble(input blk_t x);
        blk_t y;
        for (int i = 0; i < int'(BLK_W); i++) begin
            y[BLK_W-1-i] = x[BLK_W - scr_src(i)];
        end
        return y;
    endfunction

    function automatic blk_t exit_scramble(input blk_t x);
        blk_t y;
        for (int i = 0; i < int'(BLK_W); i++) begin
            y[BLK_W - scr_src(i)] = x[BLK_W-1-i];
        end
        return y;
    endfunction

    // Each 6-bit group takes 4 bits plus a wrapped neighbour on each side.
    function automatic rkey_t widen(input half_t x);
        rkey_t y;
        int    src;
        for (int g = 0; g < int'(N_SBOX); g++) begin
            for (int j = 0; j < int'(GRP_W); j++) begin
                src = 4 * g + j;
                if (src == 0)
                    src = HALF_W;
                else if (src > int'(HALF_W))
                    src = 1;
                y[RKEY_W-1-(GRP_W*g+j)] = x[HALF_W - src];
            end
        end
        return y;
    endfunction

    function automatic half_t reorder(input half_t x);
        half_t y;
        for (int i = 0; i < int'(HALF_W); i++) begin
            y[HALF_W-1-i] = x[HALF_W - PMAP[i]];
        end
        return y;
    endfunction

    // Outer bits pick the row, inner four bits pick the column.
    function automatic nib_t sub_lookup(input int box, input grp_t g);
        logic [GRP_W-1:0] idx;
        idx = {g[GRP_W-1], g[0], g[GRP_W-2:1]};
        unique case (box)
            0:       return SUB1[idx];
            1:       return SUB2[idx];
            2:       return SUB3[idx];
            3:       return SUB4[idx];
            4:       return SUB5[idx];
            5:       return SUB6[idx];
            6:       return SUB7[idx];
            default: return SUB8[idx];
        endcase
    endfunction

endpackage

// File: rtl/des_sbox.sv
module des_sbox
    import des_pkg::*;
#(
    parameter int BOX = 0
) (
    input  grp_t grp,
    output nib_t nib
);
    always_comb begin
        nib = sub_lookup(BOX, grp);
    end
endmodule

// File: rtl/des_feistel.sv
module des_feistel
    import des_pkg::*;
(
    input  half_t rhalf,
    input  rkey_t rkey,
    output half_t fout
);
    rkey_t mixed;
    half_t sub_cat;

    always_comb begin
        mixed = widen(rhalf) ^ rkey;
    end

    for (genvar g = 0; g < int'(N_SBOX); g++) begin : g_box
        des_sbox #(.BOX(g)) u_box (
            .grp (mixed[RKEY_W-1-GRP_W*g -: GRP_W]),
            .nib (sub_cat[HALF_W-1-NIB_W*g -: NIB_W])
        );
    end

    always_comb begin
        fout = reorder(sub_cat);
    end
endmodule

// File: rtl/des_seq_ctrl.sv
module des_seq_ctrl
    import des_pkg::*;
#(
    parameter int unsigned ROUNDS = 16,
    parameter int unsigned CNT_W  = $clog2(ROUNDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_n,
    output logic             load,
    output logic             running,
    output logic             fin,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

    phase_e phase;

    always_comb begin
        running = (phase == PH_RUN);
        load    = (phase == PH_IDLE) && !start_n;
        fin     = running && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (load) begin
            phase <= PH_RUN;
            cnt   <= '0;
        end else if (fin) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (running) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/des_iter_core.sv
module des_iter_core
    import des_pkg::*;
#(
    parameter int unsigned ROUNDS = 16,
    parameter int unsigned CNT_W  = $clog2(ROUNDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_n,
    input  logic             decrypt,
    input  logic [63:0]      blk_in,
    input  logic [47:0]      rkey,
    output logic [CNT_W-1:0] key_idx,
    output logic             busy,
    output logic [63:0]      blk_out,
    output logic             done
);
    localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(ROUNDS - 1);

    halves_t          st;
    halves_t          st_nxt;
    half_t            fval;
    logic             dec_q;
    logic             load;
    logic             fin;
    logic [CNT_W-1:0] cnt;

    des_seq_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_n (start_n),
        .load    (load),
        .running (busy),
        .fin     (fin),
        .cnt     (cnt)
    );

    des_feistel u_f (
        .rhalf (st.rh),
        .rkey  (rkey),
        .fout  (fval)
    );

    always_comb begin
        st_nxt.lh = st.rh;
        st_nxt.rh = st.lh ^ fval;
        key_idx   = dec_q ? (TOP_IDX - cnt) : cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            dec_q   <= 1'b0;
            blk_out <= '0;
            done    <= 1'b0;
        end else begin
            done <= fin;
            if (load) begin
                st    <= halves_t'(entry_scramble(blk_in));
                dec_q <= decrypt;
            end else if (busy) begin
                st <= st_nxt;
            end
            if (fin) begin
                blk_out <= exit_scramble({st_nxt.rh, st_nxt.lh});
            end
        end
    end
endmodule

// File: rtl/des_iter_core_chk.sv
module des_iter_core_chk #(
    parameter int unsigned ROUNDS = 16,
    parameter int unsigned CNT_W  = $clog2(ROUNDS)
) (
    input logic             clk,
    input logic             rst,
    input logic             start_n,
    input logic             decrypt,
    input logic             busy,
    input logic             done,
    input logic             dec_q,
    input logic [CNT_W-1:0] key_idx,
    input logic [63:0]      blk_out
);
    localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(ROUNDS - 1);

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_end_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_load_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_n) |=> busy);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_n) |=> !busy);

    assert_first_key_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_n) |=> (key_idx == ($past(decrypt) ? TOP_IDX : '0)));

    assert_key_up_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !dec_q && key_idx != TOP_IDX) |=> (key_idx == $past(key_idx) + 1'b1));

    assert_key_down_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && dec_q && key_idx != '0) |=> (key_idx == $past(key_idx) - 1'b1));

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && (dec_q ? (key_idx != '0) : (key_idx != TOP_IDX))) |=> busy);

    assert_mode_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(dec_q));

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(blk_out));
endmodule

bind des_iter_core des_iter_core_chk #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_n (start_n),
    .decrypt (decrypt),
    .busy    (busy),
    .done    (done),
    .dec_q   (dec_q),
    .key_idx (key_idx),
    .blk_out (blk_out)
);

// File: tb/tb_des_iter_core.sv
module tb_des_iter_core;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_n = 1'b1;
    logic        decrypt = 1'b0;
    logic [63:0] blk_in = '0;
    logic [47:0] rkey = '0;
    logic [3:0]  key_idx;
    logic        busy;
    logic [63:0] blk_out;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    logic [47:0] ks [16];

    des_iter_core dut (
        .clk     (clk),
        .rst     (rst),
        .start_n (start_n),
        .decrypt (decrypt),
        .blk_in  (blk_in),
        .rkey    (rkey),
        .key_idx (key_idx),
        .busy    (busy),
        .blk_out (blk_out),
        .done    (done)
    );

    always #(CLK_P/2) clk = ~clk;

    // External key generator model: serves the key the engine asks for.
    initial forever begin
        @(negedge clk);
        rkey = ks[key_idx];
    end

    task automatic wrap_up();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        wrap_up();
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic kat_keys();
        ks[0]  = 48'h1B02EFFC7072; ks[1]  = 48'h79AED9DBC9E5;
        ks[2]  = 48'h55FC8A42CF99; ks[3]  = 48'h72ADD6DB351D;
        ks[4]  = 48'h7CEC07EB53A8; ks[5]  = 48'h63A53E507B2F;
        ks[6]  = 48'hEC84B7F618BC; ks[7]  = 48'hF78A3AC13BFB;
        ks[8]  = 48'hE0DBEBEDE781; ks[9]  = 48'hB1F347BA464F;
        ks[10] = 48'h215FD3DED386; ks[11] = 48'h7571F59467E9;
        ks[12] = 48'h97C5D1FABA41; ks[13] = 48'h5F43B7F2E73A;
        ks[14] = 48'hBF918D3D3F0A; ks[15] = 48'hCB3D8B0E17F5;
    endtask

    // Called at a falling edge; load happens at the next rising edge.
    task automatic run_block(input logic [63:0] din, input logic dec, input bit poke,
                             output logic [63:0] dout, output int lat, output bit order_ok);
        logic [3:0] want;
        start_n = 1'b0;
        blk_in  = din;
        decrypt = dec;
        @(negedge clk);
        start_n = 1'b1;
        blk_in  = ~din;
        decrypt = ~dec;
        lat = 0;
        order_ok = 1;
        while (!done && lat < 40) begin
            want = dec ? 4'(15 - lat) : 4'(lat);
            if (!busy || key_idx != want) order_ok = 0;
            if (poke && lat == 5) begin
                start_n = 1'b0;
                blk_in  = 64'hFFFF0000FFFF0000;
            end
            if (poke && lat == 6) start_n = 1'b1;
            @(negedge clk);
            lat++;
        end
        dout = blk_out;
    endtask

    initial begin
        logic [63:0] res;
        logic [63:0] ct;
        logic [63:0] pt;
        logic [63:0] back;
        int          lat;
        bit          ok;
        bit          all_ok;

        kat_keys();
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1 done in reset", 64'(done), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 flags after reset", {62'd0, busy, done}, 64'd0);
        chk(blk_out == 64'd0, "R1 output after reset", blk_out, 64'd0);

        // R2: idle with start_n high does nothing
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R2 idle stays idle", 64'(busy), 64'd0);
        chk(blk_out == 64'd0, "R2 idle output unchanged", blk_out, 64'd0);

        // R5 R6: known-answer encryption
        run_block(64'h0123456789ABCDEF, 1'b0, 1'b0, res, lat, ok);
        chk(res == 64'h85E813540F0AB405, "R5 R6 known-answer ciphertext", res, 64'h85E813540F0AB405);
        chk(lat == 16, "R3 rounds after load edge", 64'(lat), 64'd16);
        chk(ok, "R4 encrypt key order", 64'(ok), 64'd1);
        chk(busy == 1'b0, "R3 busy low with done", 64'(busy), 64'd0);
        @(negedge clk);
        chk(done == 1'b0, "R3 done lasts one cycle", 64'(done), 64'd0);
        repeat (4) @(negedge clk);
        chk(blk_out == 64'h85E813540F0AB405, "R9 output held", blk_out, 64'h85E813540F0AB405);

        // R7: known-answer decryption
        run_block(64'h85E813540F0AB405, 1'b1, 1'b0, res, lat, ok);
        chk(res == 64'h0123456789ABCDEF, "R7 known-answer plaintext", res, 64'h0123456789ABCDEF);
        chk(ok, "R4 decrypt key order", 64'(ok), 64'd1);
        chk(lat == 16, "R3 decrypt rounds", 64'(lat), 64'd16);

        // R8: load request and mode flip during a block are ignored
        run_block(64'h0123456789ABCDEF, 1'b0, 1'b1, res, lat, ok);
        chk(res == 64'h85E813540F0AB405, "R8 mid-block load ignored", res, 64'h85E813540F0AB405);
        chk(lat == 16 && ok, "R8 timing unchanged", 64'(lat), 64'd16);
        run_block(64'h85E813540F0AB405, 1'b1, 1'b1, res, lat, ok);
        chk(res == 64'h0123456789ABCDEF, "R8 mid-block load ignored in decrypt", res, 64'h0123456789ABCDEF);

        // R2 R3: back-to-back blocks (load during the done cycle)
        run_block(64'h0123456789ABCDEF, 1'b0, 1'b0, res, lat, ok);
        run_block(res, 1'b1, 1'b0, back, lat, ok);
        chk(back == 64'h0123456789ABCDEF && lat == 16, "R2 R3 back-to-back round trip", back, 64'h0123456789ABCDEF);

        // R7 sweep: random key sets and blocks must round-trip
        all_ok = 1;
        for (int s = 0; s < 48; s++) begin
            for (int k = 0; k < 16; k++) ks[k] = {$urandom, $urandom} & 48'hFFFFFFFFFFFF;
            for (int b = 0; b < 4; b++) begin
                pt = {$urandom, $urandom};
                if (b == 0) pt = 64'd0;
                if (b == 1) pt = '1;
                run_block(pt, 1'b0, 1'b0, ct, lat, ok);
                if (!ok || lat != 16) all_ok = 0;
                run_block(ct, 1'b1, 1'b0, back, lat, ok);
                if (!ok || lat != 16) all_ok = 0;
                chk(back == pt, "R7 round trip random keys", back, pt);
            end
        end
        chk(all_ok, "R4 R3 key order and timing over sweep", 64'(all_ok), 64'd1);

        @(negedge clk);
        wrap_up();
    end
endmodule